// File: doc/BRIEF.md
# Bus Cycle Timeout Watchdog

This block guards a processor bus against cycles that never finish. It watches the active-low address strobe, which the processor lowers for every bus cycle, interrupt acknowledge cycles included. While the strobe stays low it counts clock cycles. If the count reaches a programmed limit, the block pulls two shared open-drain lines low. The first is the bus-error line, which makes the processor abort the cycle. The second is a timeout flag, which tells other agents that the error is a routine timeout and not a hardware fault.

While no timeout is pending, both lines float so that other agents on the bus can drive them. Each line is presented as an output-enable plus a drive value, and a pull-up at board level resolves the line. When the strobe rises, both enables drop at once through a combinational path. The count clears a few clocks later, once the synchronised strobe catches up.

Top module: `bus_cycle_watchdog`

## Requirements
- R1: After a synchronous active-low reset, both output-enables are 0, so both lines float.
- R2: While the address strobe is high, both output-enables stay 0.
- R3: If the strobe drops just after a clock edge and stays low, both enables become 1 after exactly LIMIT+2 rising edges: two synchroniser stages, then LIMIT counts. They are still 0 after LIMIT+1 edges.
- R4: The bus-error enable and the timeout enable always hold the same value.
- R5: Both drive values are constant 0, so an enabled line is pulled low.
- R6: Once the limit is reached, the counter saturates at LIMIT. The enables stay 1 for as long as the strobe stays low, with no toggling and no wrap.
- R7: When the strobe goes high, both enables return to 0 in the same cycle, without waiting for a clock edge.
- R8: A strobe-high interval of at least 3 clock cycles clears the count. A later low period counts from zero, so time spent low in separate cycles never adds up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_n | input | 1 | Processor address strobe, active low, asynchronous to clk |
| berr_oe | output | 1 | Output-enable for the bus-error line |
| berr_drv | output | 1 | Drive value for the bus-error line (always 0) |
| tmo_oe | output | 1 | Output-enable for the timeout line |
| tmo_drv | output | 1 | Drive value for the timeout line (always 0) |

## Verification
The bench builds the watchdog with LIMIT set to 20 instead of the default of 400,000. With this value the exact edge at which the lines assert, one edge either side of it, and a hold of several times the limit all fit in a short run. The smaller limit also makes back-to-back short cycles cheap to test: a cycle one edge short of the limit followed by a second cycle can expose any count that carries over between cycles. The synchroniser depth keeps its default of 2, so the expected assertion edge is LIMIT+2.

// File: rtl/bcw_pkg.sv
// Package: shared constants for the bus cycle timeout watchdog.
// Assumes exactly two open-drain lines, indexed by line_e.
package bcw_pkg;
    localparam int unsigned NUM_LINES = 2;

    typedef enum logic {
        LN_BUSERR = 1'b0,
        LN_TMO    = 1'b1
    } line_e;
endpackage

// File: rtl/strobe_sync.sv
// Module: strobe_sync
// Brings the asynchronous active-low strobe into the clock domain through
// STAGES flip-flops and reports an active-high "cycle in progress" flag.
// Assumes STAGES >= 2. The flops reset to the idle (high) level.
module strobe_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic active
);
    logic [STAGES-1:0] chain;

    // Purpose: shift the raw strobe through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], async_n};
        end
    end

    assign active = ~chain[STAGES-1];
endmodule

// File: rtl/cycle_counter.sv
// Module: cycle_counter
// Counts clocks while run is high, clears while run is low, and saturates
// at LIMIT. Assumes CNT_W is wide enough to hold LIMIT.
module cycle_counter #(
    parameter int unsigned LIMIT = 400000,
    parameter int unsigned CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] count,
    output logic             expired
);
    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

    // Purpose: clear when idle, count up while running, stop at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!run) begin
            count <= '0;
        end else if (count != LIM_C) begin
            count <= count + 1'b1;
        end
    end

    assign expired = (count == LIM_C);
endmodule

// File: rtl/od_line_driver.sv
// Module: od_line_driver
// Drives a set of open-drain lines as enable/value pairs. A line is enabled
// only while the timer has expired AND the raw strobe is still low, which
// gives release without waiting for a clock edge. The drive value is always 0.
module od_line_driver #(
    parameter int unsigned N = 2
) (
    input  logic         expired,
    input  logic         strobe_n,
    output logic [N-1:0] oe,
    output logic [N-1:0] drv
);
    logic pull;

    // Purpose: combine the expiry flag with the raw strobe.
    always_comb begin
        pull = expired & ~strobe_n;
    end

    for (genvar i = 0; i < N; i++) begin : g_line
        assign oe[i]  = pull;
        assign drv[i] = 1'b0;
    end
endmodule

// File: rtl/bus_cycle_watchdog.sv
// Module: bus_cycle_watchdog (top)
// Flags bus cycles whose address strobe stays low for LIMIT clocks after
// synchronisation by pulling the bus-error and timeout lines low. Assumes the
// board pulls both lines up and that other agents may also drive them.
module bus_cycle_watchdog
    import bcw_pkg::*;
#(
    parameter int unsigned LIMIT       = 400000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic berr_oe,
    output logic berr_drv,
    output logic tmo_oe,
    output logic tmo_drv
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic                 cyc_active;
    logic [CNT_W-1:0]     cnt;
    logic                 expired;
    logic [NUM_LINES-1:0] line_oe;
    logic [NUM_LINES-1:0] line_drv;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (strobe_n),
        .active  (cyc_active)
    );

    cycle_counter #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cyc_active),
        .count   (cnt),
        .expired (expired)
    );

    od_line_driver #(.N(NUM_LINES)) u_drv (
        .expired  (expired),
        .strobe_n (strobe_n),
        .oe       (line_oe),
        .drv      (line_drv)
    );

    assign berr_oe  = line_oe[LN_BUSERR];
    assign berr_drv = line_drv[LN_BUSERR];
    assign tmo_oe   = line_oe[LN_TMO];
    assign tmo_drv  = line_drv[LN_TMO];
endmodule

// File: rtl/bus_cycle_watchdog_chk.sv
// Module: bus_cycle_watchdog_chk
// Checker bound into bus_cycle_watchdog. It keeps its own count of strobe-low
// clocks so that it can check the assertion window without deep $past.
module bus_cycle_watchdog_chk #(
    parameter int unsigned LIMIT = 400000,
    parameter int unsigned CNT_W = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strobe_n,
    input logic             berr_oe,
    input logic             berr_drv,
    input logic             tmo_oe,
    input logic             tmo_drv,
    input logic [CNT_W-1:0] cnt
);
    logic [31:0] low_run;

    // Purpose: count consecutive sampled strobe-low clocks, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (strobe_n) begin
            low_run <= '0;
        end else if (low_run != 32'hFFFF_FFFF) begin
            low_run <= low_run + 1'b1;
        end
    end

    AST_IDLE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_n |-> (!berr_oe && !tmo_oe));                          // R2
    AST_LINES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        berr_oe == tmo_oe);                                           // R4
    AST_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_drv == 1'b0) && (tmo_drv == 1'b0));                     // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(LIMIT));                                        // R6
    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (berr_oe && !strobe_n) |=> (berr_oe || strobe_n));            // R6
    AST_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(berr_oe) |-> (low_run >= LIMIT));                       // R3
endmodule

bind bus_cycle_watchdog bus_cycle_watchdog_chk #(
    .LIMIT(LIMIT), .CNT_W(CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_n (strobe_n),
    .berr_oe  (berr_oe),
    .berr_drv (berr_drv),
    .tmo_oe   (tmo_oe),
    .tmo_drv  (tmo_drv),
    .cnt      (cnt)
);

// File: tb/bus_cycle_watchdog_tb.sv
// Bench: directed scenarios, one task each, with a watchdog and pull-up lines.
module bus_cycle_watchdog_tb;
    localparam int unsigned LIM = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe_n = 1'b1;
    logic berr_oe, berr_drv, tmo_oe, tmo_drv;
    logic berr_line, tmo_line;
    int   errs = 0;
    int   checks = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    bus_cycle_watchdog #(.LIMIT(LIM)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .berr_oe  (berr_oe),
        .berr_drv (berr_drv),
        .tmo_oe   (tmo_oe),
        .tmo_drv  (tmo_drv)
    );

    // Pull-up resolution of each shared line.
    assign berr_line = berr_oe ? berr_drv : 1'b1;
    assign tmo_line  = tmo_oe  ? tmo_drv  : 1'b1;

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: {berr_oe,tmo_oe,berr_line,tmo_line} actual=%b expected=%b",
                     req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {berr_oe, tmo_oe, berr_line, tmo_line};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", outs(), 4'b0011);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_idle();
        strobe_n = 1'b1;
        repeat (LIM + 5) @(negedge clk);
        chk("R2", outs(), 4'b0011);
    endtask

    task automatic t_timeout();
        @(negedge clk);
        strobe_n = 1'b0;
        repeat (LIM + 1) @(negedge clk);
        chk("R3 not early", outs(), 4'b0011);
        @(negedge clk);
        chk("R3 R4 R5 asserted", outs(), 4'b1100);
        for (int i = 0; i < 3 * LIM; i++) begin
            @(negedge clk);
            if (outs() !== 4'b1100 || i == 3 * LIM - 1) chk("R6 held", outs(), 4'b1100);
        end
        strobe_n = 1'b1;
        #1;
        chk("R7 immediate release", outs(), 4'b0011);
        repeat (5) @(negedge clk);
        chk("R2 idle after release", outs(), 4'b0011);
    endtask

    task automatic t_restart();
        @(negedge clk);
        strobe_n = 1'b0;
        repeat (LIM - 1) @(negedge clk);
        chk("R8 short cycle", outs(), 4'b0011);
        strobe_n = 1'b1;
        repeat (3) @(negedge clk);
        strobe_n = 1'b0;
        repeat (LIM + 1) @(negedge clk);
        chk("R8 no carry-over", outs(), 4'b0011);
        @(negedge clk);
        chk("R8 R3 fresh count expires", outs(), 4'b1100);
        strobe_n = 1'b1;
        #1;
        chk("R7 release again", outs(), 4'b0011);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        strobe_n = 1'b0;
        repeat (LIM + 4) @(negedge clk);
        chk("R6 before reset", outs(), 4'b1100);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset during timeout", outs(), 4'b0011);
        strobe_n = 1'b1;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_timeout();
        t_restart();
        t_reset_mid();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule